// File: doc/BRIEF.md
# Board Interrupt Aggregation Registers

This block gathers interrupt requests from on-board peripherals into three groups and drives one CPU interrupt line per group: a local group with two serial-port sources, an expansion-bus (ISA) group with two disk channels, and a PCI group. Each source has a pending latch that is set on a rising edge of its request input. The CPU finds the cause by reading the group's status register. That read returns the enabled pending sources and acknowledges them in the same access.

Software enables the sources of a group by writing a 1 to each source's bit. A write to the expansion-bus group also opens a cascade path, and that group's CPU line can only assert once the path is open. The register window also holds four LED registers that take writes and ignore them, and keyboard and panic registers that read as zero. The bus is a simple synchronous register port. Read data is registered and appears in the cycle after the read strobe.

Top module: `board_irq_regs`

## Requirements
- R1: A read at byte address 0x10 (local status) returns bit 0 = serial source 0 pending and enabled, bit 1 = serial source 1 pending and enabled, and all other bits zero.
- R2: A write to 0x10 sets each serial source's enable from its bit: 1 enables the source and 0 masks it. A masked source still latches its pending state but does not show in status or on `irq_loc`.
- R3: A read of 0x10 clears both serial pending latches, so `irq_loc` is low in the next cycle unless a new edge arrived.
- R4: A read at 0x18 (expansion-bus status) returns bit 0 = bridge source (always 0), bit 1 = disk channel 0 and bit 2 = disk channel 1, each pending and enabled. The read clears both disk latches and drops `irq_isa`.
- R5: A write to 0x18 sets the disk 0 enable from bit 1 and the disk 1 enable from bit 2, and always sets `casc_open`. `irq_isa` is never high while `casc_open` is low.
- R6: A rising edge on a request input sets its pending latch. An edge in the same cycle as an acknowledging read of its group wins, and the latch stays set.
- R7: `irq_loc` is high exactly when some enabled serial source is pending. `irq_isa` is high exactly when `casc_open` is high and some enabled disk source is pending.
- R8: A rising edge of `pci_req` sets the PCI pending latch, which drives `irq_pci`. A read at 0x14 returns zero and clears that latch.
- R9: Reads of the keyboard (0x1C) and panic (0x20) registers, the LED registers and any unmapped address return zero.
- R10: Writes to the LED registers (0x00, 0x04, 0x08, 0x0C) change no enable, latch, cascade state or output.
- R11: After reset all sources are masked, all latches are clear, `casc_open` is low, and all lines and `bus_rdata` are zero.
- R12: `bus_rdata` updates in the cycle after `bus_rd` and holds its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| ser_req | input | 2 | Serial source requests |
| disk_req | input | 2 | Disk channel requests |
| pci_req | input | 1 | PCI request |
| irq_loc | output | 1 | Local group CPU line |
| irq_pci | output | 1 | PCI group CPU line |
| irq_isa | output | 1 | Expansion-bus group CPU line |
| casc_open | output | 1 | Cascade path open |

## Verification
The bench drives an edge in the same cycle as the read that acknowledges its group. A design where the clear wins would lose that request and drop the line. It raises a request while the source is masked and then enables it. A design that gated the latch with the mask would miss the old request, and one that ignored the mask would raise the line too early. It checks that the disk line stays low until the first expansion-bus write opens the cascade, and that a zero written to an LED register leaves an active line unchanged. A decoder that aliased the LED registers onto a status register would mask that source.

// File: rtl/board_irq_pkg.sv
package board_irq_pkg;

    localparam int REG_ADDR_W = 8;
    localparam int BUS_DATA_W = 32;
    localparam int N_SER      = 2;
    localparam int N_DISK     = 2;

    localparam logic [REG_ADDR_W-1:0] OFS_LED0  = 8'h00;
    localparam logic [REG_ADDR_W-1:0] OFS_LED3  = 8'h0C;
    localparam logic [REG_ADDR_W-1:0] OFS_LOC   = 8'h10;
    localparam logic [REG_ADDR_W-1:0] OFS_PCI   = 8'h14;
    localparam logic [REG_ADDR_W-1:0] OFS_ISA   = 8'h18;
    localparam logic [REG_ADDR_W-1:0] OFS_KBD   = 8'h1C;
    localparam logic [REG_ADDR_W-1:0] OFS_PANIC = 8'h20;

    localparam int ISA_DISK_LSB = 1;

    typedef struct packed {
        logic led;
        logic loc;
        logic pci;
        logic isa;
        logic kbd;
        logic panic;
    } reg_hit_t;

    function automatic logic is_led(input logic [REG_ADDR_W-1:0] a);
        return (a >= OFS_LED0) && (a <= OFS_LED3) && (a[1:0] == 2'b00);
    endfunction

endpackage

// File: rtl/board_irq_decode.sv
module board_irq_decode
    import board_irq_pkg::*;
(
    input  logic [REG_ADDR_W-1:0] addr,
    output reg_hit_t              hit
);
    always_comb begin
        hit       = '0;
        hit.led   = is_led(addr);
        hit.loc   = (addr == OFS_LOC);
        hit.pci   = (addr == OFS_PCI);
        hit.isa   = (addr == OFS_ISA);
        hit.kbd   = (addr == OFS_KBD);
        hit.panic = (addr == OFS_PANIC);
    end
endmodule

// File: rtl/irq_edge_group.sv
module irq_edge_group #(
    parameter int   N_SRC    = 2,
    parameter logic EN_RESET = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] req,
    input  logic             ack,
    input  logic             en_we,
    input  logic [N_SRC-1:0] en_wdata,
    output logic [N_SRC-1:0] status
);
    logic [N_SRC-1:0] req_q;
    logic [N_SRC-1:0] pend_q;
    logic [N_SRC-1:0] en_q;
    logic [N_SRC-1:0] rise;

    always_ff @(posedge clk) begin
        if (rst) req_q <= '0;
        else     req_q <= req;
    end

    assign rise = req & ~req_q;

    always_ff @(posedge clk) begin
        if (rst)        en_q <= {N_SRC{EN_RESET}};
        else if (en_we) en_q <= en_wdata;
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst)          pend_q[i] <= 1'b0;
            else if (rise[i]) pend_q[i] <= 1'b1;
            else if (ack)     pend_q[i] <= 1'b0;
        end
    end

    assign status = pend_q & en_q;

    // R6: an edge always leaves its latch set, even during an acknowledge
    a_r6_edge_wins: assert property (@(posedge clk) disable iff (rst)
        (|rise) |=> ((pend_q & $past(rise)) == $past(rise)));

    // R3: an acknowledge with no new edge empties the group
    a_r3_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack && (rise == '0)) |=> (pend_q == '0));
endmodule

// File: rtl/board_irq_regs.sv
module board_irq_regs
    import board_irq_pkg::*;
#(
    parameter int DATA_W = BUS_DATA_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [N_SER-1:0]      ser_req,
    input  logic [N_DISK-1:0]     disk_req,
    input  logic                  pci_req,
    output logic                  irq_loc,
    output logic                  irq_pci,
    output logic                  irq_isa,
    output logic                  casc_open
);
    localparam int ISA_DISK_MSB = ISA_DISK_LSB + N_DISK - 1;

    reg_hit_t          hit;
    logic [N_SER-1:0]  st_loc;
    logic [N_DISK-1:0] st_isa;
    logic [0:0]        st_pci;
    logic              casc_q;
    logic [DATA_W-1:0] rd_next;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:ISA_DISK_MSB+1];

    board_irq_decode u_dec (
        .addr (bus_addr),
        .hit  (hit)
    );

    irq_edge_group #(.N_SRC(N_SER), .EN_RESET(1'b0)) u_loc (
        .clk      (clk),
        .rst      (rst),
        .req      (ser_req),
        .ack      (bus_rd && hit.loc),
        .en_we    (bus_wr && hit.loc),
        .en_wdata (bus_wdata[N_SER-1:0]),
        .status   (st_loc)
    );

    irq_edge_group #(.N_SRC(N_DISK), .EN_RESET(1'b0)) u_isa (
        .clk      (clk),
        .rst      (rst),
        .req      (disk_req),
        .ack      (bus_rd && hit.isa),
        .en_we    (bus_wr && hit.isa),
        .en_wdata (bus_wdata[ISA_DISK_MSB:ISA_DISK_LSB]),
        .status   (st_isa)
    );

    irq_edge_group #(.N_SRC(1), .EN_RESET(1'b1)) u_pci (
        .clk      (clk),
        .rst      (rst),
        .req      (pci_req),
        .ack      (bus_rd && hit.pci),
        .en_we    (1'b0),
        .en_wdata (1'b0),
        .status   (st_pci)
    );

    always_ff @(posedge clk) begin
        if (rst)                    casc_q <= 1'b0;
        else if (bus_wr && hit.isa) casc_q <= 1'b1;
    end

    always_comb begin
        rd_next = '0;
        if (hit.loc) rd_next[N_SER-1:0] = st_loc;
        if (hit.isa) rd_next[ISA_DISK_MSB:ISA_DISK_LSB] = st_isa;
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end

    assign irq_loc   = |st_loc;
    assign irq_isa   = casc_q & (|st_isa);
    assign irq_pci   = st_pci[0];
    assign casc_open = casc_q;

    // R5: any write to the expansion-bus register opens the cascade
    a_r5_cascade_opens: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && hit.isa) |=> casc_open);

    // R5: closed cascade keeps the disk line quiet
    a_r5_gate_closed: assert property (@(posedge clk) disable iff (rst)
        !casc_open |-> !irq_isa);

    // R9: stub, LED and unmapped reads give zero
    a_r9_stub_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !hit.loc && !hit.isa) |=> (bus_rdata == '0));

    // R12: read data holds between reads
    a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/board_irq_regs_bench.sv
module board_irq_regs_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  ser_req = '0;
    logic [1:0]  disk_req = '0;
    logic        pci_req = 1'b0;
    logic        irq_loc, irq_pci, irq_isa, casc_open;

    int n_checks = 0;
    int n_fail   = 0;

    logic [1:0]  m_pend_s = '0, m_en_s = '0, m_prev_s = '0;
    logic [1:0]  m_pend_d = '0, m_en_d = '0, m_prev_d = '0;
    logic        m_pend_p = 1'b0, m_prev_p = 1'b0, m_casc = 1'b0;
    logic [31:0] m_rdata = '0;

    always #4 clk = ~clk;

    board_irq_regs u_board_irq_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ser_req(ser_req), .disk_req(disk_req), .pci_req(pci_req),
        .irq_loc(irq_loc), .irq_pci(irq_pci), .irq_isa(irq_isa),
        .casc_open(casc_open)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "rdata",   bus_rdata, m_rdata);
        chk(tag, "irq_loc", {31'b0, irq_loc}, {31'b0, |(m_pend_s & m_en_s)});
        chk(tag, "irq_isa", {31'b0, irq_isa}, {31'b0, m_casc & |(m_pend_d & m_en_d)});
        chk(tag, "irq_pci", {31'b0, irq_pci}, {31'b0, m_pend_p});
        chk(tag, "casc",    {31'b0, casc_open}, {31'b0, m_casc});
    endtask

    // expected next state from the requirements
    task automatic model(input logic [7:0] a, input logic w, input logic r,
                         input logic [31:0] d, input logic [1:0] s,
                         input logic [1:0] k, input logic p);
        logic [1:0] rs, rk;
        logic rp, cs, ck, cp;
        rs = s & ~m_prev_s; rk = k & ~m_prev_d; rp = p & ~m_prev_p;
        cs = 1'b0; ck = 1'b0; cp = 1'b0;
        if (r) begin
            m_rdata = '0;
            if (a == 8'h10) begin m_rdata[1:0] = m_pend_s & m_en_s; cs = 1'b1; end
            if (a == 8'h18) begin m_rdata[2:1] = m_pend_d & m_en_d; ck = 1'b1; end
            if (a == 8'h14) cp = 1'b1;
        end
        if (w && a == 8'h10) m_en_s = d[1:0];
        if (w && a == 8'h18) begin m_en_d = d[2:1]; m_casc = 1'b1; end
        m_pend_s = (m_pend_s & ~{2{cs}}) | rs;
        m_pend_d = (m_pend_d & ~{2{ck}}) | rk;
        m_pend_p = (m_pend_p & ~cp) | rp;
        m_prev_s = s; m_prev_d = k; m_prev_p = p;
    endtask

    task automatic step(input string tag, input logic [7:0] a, input logic w,
                        input logic r, input logic [31:0] d, input logic [1:0] s,
                        input logic [1:0] k, input logic p);
        bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
        ser_req = s; disk_req = k; pci_req = p;
        model(a, w, r, d, s, k, p);
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic idle(input string tag);
        step(tag, 8'h44, 1'b0, 1'b0, 32'h0, 2'b00, 2'b00, 1'b0);
    endtask

    initial begin
        #1_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] addrs [9];
        void'($urandom(32'd4242));
        addrs = '{8'h00, 8'h04, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h31};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_all("R11");

        // R2: masked source latches but does not raise the line
        step("R2", 8'h44, 0, 0, 0, 2'b01, 2'b00, 0);
        idle("R2");
        step("R2", 8'h10, 1, 0, 32'h1, 2'b01, 2'b00, 0);
        idle("R7");
        // R10: LED write of zero leaves the enabled source active
        step("R10", 8'h00, 1, 0, 32'h0, 2'b00, 2'b00, 0);
        step("R10", 8'h0C, 1, 0, 32'h0, 2'b00, 2'b00, 0);
        // R1 and R3: read reports then clears
        step("R1", 8'h10, 0, 1, 0, 2'b00, 2'b00, 0);
        idle("R3");
        // R6: edge during acknowledge survives
        step("R2", 8'h10, 1, 0, 32'h3, 2'b00, 2'b00, 0);
        step("R6", 8'h10, 0, 1, 0, 2'b10, 2'b00, 0);
        step("R6", 8'h10, 0, 1, 0, 2'b10, 2'b00, 0);
        idle("R3");
        // R5: disk pending before cascade is open stays off the line
        step("R5", 8'h44, 0, 0, 0, 2'b00, 2'b10, 0);
        idle("R5");
        step("R5", 8'h18, 1, 0, 32'h4, 2'b00, 2'b00, 0);
        idle("R7");
        step("R4", 8'h18, 0, 1, 0, 2'b00, 2'b00, 0);
        idle("R4");
        // R8: PCI latch and zero read
        step("R8", 8'h44, 0, 0, 0, 2'b00, 2'b00, 1);
        step("R8", 8'h14, 0, 1, 0, 2'b00, 2'b00, 0);
        idle("R8");
        // R9 and R12: stub reads and hold
        step("R9", 8'h1C, 0, 1, 0, 2'b00, 2'b00, 0);
        step("R9", 8'h20, 0, 1, 0, 2'b00, 2'b00, 0);
        step("R9", 8'h31, 0, 1, 0, 2'b00, 2'b00, 0);
        step("R12", 8'h10, 1, 0, 32'h3, 2'b11, 2'b00, 0);
        step("R12", 8'h10, 0, 1, 0, 2'b00, 2'b00, 0);
        idle("R12");
        idle("R12");

        for (int i = 0; i < 3000; i++) begin
            logic [7:0] a;
            a = addrs[$urandom_range(8)];
            step("R7", a, ($urandom_range(3) == 0), ($urandom_range(2) == 0),
                 $urandom, 2'($urandom), 2'($urandom), 1'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule